// File: doc/BRIEF.md
# AHB Bus Hang Watchdog

This block sits on the response path between an AHB interconnect's ready/response multiplexer and the bus master. It follows the master's transfer handshake to know when a data phase is outstanding. While one is outstanding, it counts consecutive cycles in which the slave-side ready is low. Wait states that end before the programmable limit pass through untouched. A wait that reaches the limit is declared a hang.

On a hang, the block takes over the response lines toward the master and injects a protocol-legal two-cycle ERROR response, so the master can abandon the transfer instead of freezing. It never completes the stuck transfer with an OKAY. It also records the address of the hung transfer, raises an interrupt that stays set until it is cleared by a pulse, and can emit a one-cycle reset request aimed at the offending slave.

Top module: `ahb_hang_guard`

## Requirements
- R1: Outside an injected error, the master-side ready and response equal the slave-side ready and response in the same cycle (combinational pass-through). Response encoding: 0 = OKAY, 1 = ERROR.
- R2: A data phase whose slave-side ready stays low for fewer than LIMIT consecutive cycles and then rises completes normally, with OKAY and no interrupt, however close to LIMIT the wait is.
- R3: When an outstanding data phase sees the slave-side ready low for LIMIT consecutive cycles, a hang is declared at the end of the LIMIT-th low cycle, and the interrupt is high from the next cycle.
- R4: After a hang is declared, the next cycle drives ERROR with ready low to the master, and the cycle after that drives ERROR with ready high. Slave-side ready and response are ignored during both cycles. Pass-through then resumes.
- R5: The interrupt is sticky: it stays high until the clear input is sampled high at a clock edge. If a new hang is declared at the same edge as a clear, the interrupt stays high.
- R6: The recorded hang address is the address presented with the hung transfer in its address phase. A transfer is accepted at an edge where the transfer type is NONSEQ (2'b10) or SEQ (2'b11) and the master-side ready is high. IDLE is 2'b00 and BUSY is 2'b01.
- R7: With no outstanding data phase, a low slave-side ready never advances the count and never declares a hang. The count saturates, so a single hang produces exactly one error injection and one reset pulse.
- R8: With RST_REQ_EN set, the reset request is high for exactly one cycle, the first ERROR cycle of each recovery.
- R9: After reset, the interrupt, the recorded address and the reset request are all zero, and the block is in pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| htransM | input | 2 | Transfer type from the master |
| haddrM | input | ADDR_W | Address from the master |
| hreadyS | input | 1 | Ready from the interconnect's slave mux |
| hrespS | input | 1 | Response from the interconnect's slave mux |
| irqClr | input | 1 | Pulse high to clear the hang interrupt |
| hreadyM | output | 1 | Ready toward the master |
| hrespM | output | 1 | Response toward the master |
| irq | output | 1 | Sticky hang interrupt |
| hangAddr | output | ADDR_W | Address of the most recent hung transfer |
| slvRstReq | output | 1 | One-cycle reset request for the hung slave |

## Verification
Two functions can meet in the same cycle: the interrupt clear, and the declaration of a new hang that sets the interrupt. The bench leaves the interrupt set from a previous hang, then starts a second hang and drives the clear pulse in exactly the LIMIT-th low cycle, so both land on the same edge. The result is judged one cycle later: the interrupt must still be high, the recorded address must be the second transfer's address, and the ERROR must begin. A separate cycle then pulses the clear alone, and the interrupt must drop.

// File: rtl/ahb_hang_pkg.sv
package ahb_hang_pkg;

  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_BUSY   = 2'b01;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [1:0] HTRANS_SEQ    = 2'b11;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  // recovery sequencer states
  typedef enum logic [1:0] {
    WD_PASS = 2'd0,
    WD_ERR1 = 2'd1,
    WD_ERR2 = 2'd2
  } wdState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntInc;     // a low-ready cycle inside a pending data phase
    logic cntClr;     // ready seen high toward the master
    logic addrCap;    // transfer accepted: capture its address
    logic hangLatch;  // hang declared this edge
    logic irqClr;     // software clear
  } wdStrobe_t;

endpackage

// File: rtl/ahb_hang_dp.sv
module ahb_hang_dp
  import ahb_hang_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIMIT  = 1024,
  parameter int unsigned CNT_W  = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strb,
  input  logic [ADDR_W-1:0] haddrM,
  output logic              limitHit,
  output logic              irq,
  output logic [ADDR_W-1:0] hangAddr
);

  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0]  lowCnt;
  logic [ADDR_W-1:0] addrPh;

  // consecutive low-ready counter, saturating at LIMIT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strb.cntClr) begin
      lowCnt <= '0;
    end else if (strb.cntInc && (lowCnt != CNT_SAT)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // the current cycle is the LIMIT-th low cycle when this is true
  assign limitHit = (lowCnt == CNT_LAST);

  // address of the data phase in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPh <= '0;
    end else if (strb.addrCap) begin
      addrPh <= haddrM;
    end
  end

  // status: hung address and sticky interrupt (set beats clear)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hangAddr <= '0;
      irq      <= 1'b0;
    end else begin
      if (strb.hangLatch) begin
        hangAddr <= addrPh;
      end
      if (strb.hangLatch) begin
        irq <= 1'b1;
      end else if (strb.irqClr) begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ahb_hang_ctrl.sv
module ahb_hang_ctrl
  import ahb_hang_pkg::*;
#(
  parameter bit RST_REQ_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] htransM,
  input  logic      hreadyS,
  input  logic      hrespS,
  input  logic      irqClr,
  input  logic      limitHit,
  output wdStrobe_t strb,
  output logic      hreadyM,
  output logic      hrespM,
  output logic      slvRstReq
);

  wdState_t stQ, stD;
  logic     pendQ;
  logic     accept;
  logic     lowInPhase;
  logic     fire;

  // response lines toward the master
  always_comb begin
    unique case (stQ)
      WD_ERR1: begin hreadyM = 1'b0; hrespM = RESP_ERROR; end
      WD_ERR2: begin hreadyM = 1'b1; hrespM = RESP_ERROR; end
      default: begin hreadyM = hreadyS; hrespM = hrespS; end
    endcase
  end

  assign accept     = ((htransM == HTRANS_NONSEQ) || (htransM == HTRANS_SEQ)) && hreadyM;
  assign lowInPhase = pendQ && (stQ == WD_PASS) && !hreadyS;
  assign fire       = lowInPhase && limitHit;

  // data-phase tracking: pending from acceptance until ready high to master
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (accept) begin
      pendQ <= 1'b1;
    end else if (hreadyM) begin
      pendQ <= 1'b0;
    end
  end

  always_comb begin
    stD = stQ;
    unique case (stQ)
      WD_PASS: if (fire) stD = WD_ERR1;
      WD_ERR1: stD = WD_ERR2;
      WD_ERR2: stD = WD_PASS;
      default: stD = WD_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ <= WD_PASS;
    end else begin
      stQ <= stD;
    end
  end

  always_comb begin
    strb.cntInc    = lowInPhase;
    strb.cntClr    = hreadyM;
    strb.addrCap   = accept;
    strb.hangLatch = fire;
    strb.irqClr    = irqClr;
  end

  generate
    if (RST_REQ_EN) begin : g_rstReq
      logic rstReqQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rstReqQ <= 1'b0;
        end else begin
          rstReqQ <= fire;
        end
      end
      assign slvRstReq = rstReqQ;
    end else begin : g_noRstReq
      assign slvRstReq = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ahb_hang_guard.sv
module ahb_hang_guard
  import ahb_hang_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIMIT      = 1024,
  parameter bit          RST_REQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        htransM,
  input  logic [ADDR_W-1:0] haddrM,
  input  logic              hreadyS,
  input  logic              hrespS,
  input  logic              irqClr,
  output logic              hreadyM,
  output logic              hrespM,
  output logic              irq,
  output logic [ADDR_W-1:0] hangAddr,
  output logic              slvRstReq
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  wdStrobe_t strb;
  logic      limitHit;

  ahb_hang_ctrl #(
    .RST_REQ_EN(RST_REQ_EN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .htransM   (htransM),
    .hreadyS   (hreadyS),
    .hrespS    (hrespS),
    .irqClr    (irqClr),
    .limitHit  (limitHit),
    .strb      (strb),
    .hreadyM   (hreadyM),
    .hrespM    (hrespM),
    .slvRstReq (slvRstReq)
  );

  ahb_hang_dp #(
    .ADDR_W(ADDR_W),
    .LIMIT (LIMIT),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .haddrM   (haddrM),
    .limitHit (limitHit),
    .irq      (irq),
    .hangAddr (hangAddr)
  );

endmodule

// File: rtl/ahb_hang_guard_chk.sv
module ahb_hang_guard_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqClr,
  input logic              hreadyM,
  input logic              hrespM,
  input logic              irq,
  input logic [ADDR_W-1:0] hangAddr,
  input logic              slvRstReq
);

  // R4: an ERROR with ready low is always followed by ERROR with ready high
  p_err_two_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hrespM && !hreadyM) |=> (hrespM && hreadyM));

  // R5: interrupt only drops after a clear
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  // R3/R4: a fresh interrupt coincides with the first ERROR cycle, never OKAY
  p_irq_with_error_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (hrespM && !hreadyM));

  // R6: the recorded address only changes as an error starts
  p_addr_on_hang_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hangAddr) |-> (hrespM && !hreadyM));

  // R8: reset request is a single-cycle pulse in the first ERROR cycle
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    slvRstReq |=> !slvRstReq);

  p_rst_in_err1_r8: assert property (@(posedge clk) disable iff (!rstN)
    slvRstReq |-> (hrespM && !hreadyM));

endmodule

bind ahb_hang_guard ahb_hang_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqClr    (irqClr),
  .hreadyM   (hreadyM),
  .hrespM    (hrespM),
  .irq       (irq),
  .hangAddr  (hangAddr),
  .slvRstReq (slvRstReq)
);

// File: tb/ahb_hang_guard_tb.sv
`timescale 1ns/1ps
module ahb_hang_guard_tb;

  localparam int AW  = 16;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    htransM = 2'b00;
  logic [AW-1:0] haddrM = '0;
  logic          hreadyS = 1'b1;
  logic          hrespS = 1'b0;
  logic          irqClr = 1'b0;
  logic          hreadyM, hrespM, irq, slvRstReq;
  logic [AW-1:0] hangAddr;

  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  ahb_hang_guard #(.ADDR_W(AW), .LIMIT(LIM), .RST_REQ_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .htransM(htransM), .haddrM(haddrM),
    .hreadyS(hreadyS), .hrespS(hrespS), .irqClr(irqClr),
    .hreadyM(hreadyM), .hrespM(hrespM), .irq(irq),
    .hangAddr(hangAddr), .slvRstReq(slvRstReq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // one transfer: address phase, then a slave that holds ready low for w cycles
  task automatic runXfer(input logic [AW-1:0] addr, input int w,
                         input logic [1:0] tr, input bit clrAtFire, input bit irqBefore);
    bit hangExp = (w >= LIM);
    bit done = 0;
    @(negedge clk);
    htransM = tr; haddrM = addr; hreadyS = 1'b1; hrespS = 1'b0;
    #1 check("R1", "ready in addr phase", hreadyM, 1);
    @(negedge clk);
    htransM = 2'b00; haddrM = ~addr;
    for (int i = 1; i <= w + LIM + 4 && !done; i++) begin
      hreadyS = (i > w);
      irqClr  = clrAtFire && (i == LIM);
      #1;
      if (!hangExp) begin
        if (i <= w) begin
          check("R2", "ready during wait", hreadyM, 0);
        end else begin
          check("R2", "ready at end", hreadyM, 1);
          check("R2", "resp at end", hrespM, 0);
          check("R5", "irq after bounded wait", irq, irqBefore);
          done = 1;
        end
      end else if (i <= LIM) begin
        check("R1", "ready passthrough low", hreadyM, 0);
        check("R1", "resp passthrough", hrespM, 0);
      end else if (i == LIM + 1) begin
        check("R4", "err1 ready", hreadyM, 0);
        check("R4", "err1 resp", hrespM, 1);
        check("R8", "rst req in err1", slvRstReq, 1);
        check("R3", "irq after hang", irq, 1);
        check("R6", "hang address", hangAddr, addr);
      end else if (i == LIM + 2) begin
        check("R4", "err2 ready", hreadyM, 1);
        check("R4", "err2 resp", hrespM, 1);
        check("R8", "rst req pulse end", slvRstReq, 0);
      end else begin
        check("R7", "idle passthrough", hreadyM, hreadyS);
        check("R7", "no refire", slvRstReq, 0);
        if (i > w) done = 1;
      end
      @(negedge clk);
    end
    irqClr = 1'b0;
    hreadyS = 1'b1;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    #1 check("R5", "irq after clear", irq, 0);
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9", "irq at reset", irq, 0);
    check("R9", "addr at reset", hangAddr, 0);
    check("R9", "rst req at reset", slvRstReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1 check("R9", "passthrough after reset", hreadyM, 1);

    // sweep every wait length across the limit, both accepted transfer types
    for (int w = 0; w <= LIM + 12; w++) begin
      logic [AW-1:0] a = AW'(16'h4000 + w * 16'h0104);
      runXfer(a, w, (w % 2 == 0) ? 2'b10 : 2'b11, 1'b0, 1'b0);
      if (w >= LIM) pulseClear();
    end

    // R5: sticky across a later healthy transfer
    runXfer(16'hBEE0, LIM + 1, 2'b10, 1'b0, 1'b0);
    runXfer(16'h1234, LIM - 1, 2'b11, 1'b0, 1'b1);
    // R5: clear and a new hang on the same edge: set wins, address replaced
    runXfer(16'hCAF4, LIM, 2'b10, 1'b1, 1'b1);
    #1 check("R5", "irq kept over same-edge clear", irq, 1);
    check("R6", "address of second hang", hangAddr, 16'hCAF4);
    pulseClear();

    // R1: a slave's own two-cycle ERROR passes through untouched
    @(negedge clk);
    htransM = 2'b10; haddrM = 16'h0F00;
    @(negedge clk);
    htransM = 2'b00; hreadyS = 1'b0; hrespS = 1'b1;
    #1 check("R1", "slave err1 ready", hreadyM, 0);
    check("R1", "slave err1 resp", hrespM, 1);
    @(negedge clk);
    hreadyS = 1'b1;
    #1 check("R1", "slave err2 ready", hreadyM, 1);
    check("R1", "slave err2 resp", hrespM, 1);
    @(negedge clk);
    hrespS = 1'b0;
    #1 check("R1", "slave err no irq", irq, 0);

    // R7: idle bus with ready low far beyond the limit
    hreadyS = 1'b0;
    for (int k = 0; k < 3 * LIM; k++) begin
      @(negedge clk);
      #1 if (slvRstReq !== 1'b0 || irq !== 1'b0) check("R7", "idle low timeout", 1, 0);
    end
    check("R7", "idle irq", irq, 0);
    hreadyS = 1'b1;

    // R7: BUSY is not a transfer start
    @(negedge clk);
    htransM = 2'b01; haddrM = 16'h7777;
    @(negedge clk);
    htransM = 2'b00; hreadyS = 1'b0;
    repeat (LIM + 3) @(negedge clk);
    #1 check("R7", "busy no timeout", irq, 0);
    hreadyS = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule